// File: doc/BRIEF.md
# Frame-Deferred Host Interrupt Gatherer

This block collects interrupt causes for a USB host controller and reduces them to one active-low, level-sensitive interrupt line. The causes fall into two groups. Schedule events are the completion of a transfer descriptor that asked for an interrupt, and a transaction error. Controller faults are errors in the controller's own operation.

Schedule events that arrive during a frame go into a pending set and are not seen by software yet. The schedule walker pulses `frame_end` once the status of the frame's last finished transaction has been written back to memory. On that cycle the pending set moves into the status register and then empties for the next frame. Controller faults skip this step and reach the status register one cycle after they occur.

Software masks schedule causes through an enable register and clears status bits by writing ones to them. The line stays low until every cause that drives it has been cleared.

Top module: `usbh_irq_gather`

## Requirements
- R1: While `rst` is high, or after it, the status, enable and pending state are zero and `irq_n` is 1.
- R2: A schedule event does not appear in the status register before a `frame_end` pulse. It appears on the clock edge that samples `frame_end`. Status bit 0 is descriptor completion and bit 1 is transaction error.
- R3: An event in the same cycle as `frame_end` belongs to the frame that is closing. The pending set is empty after the strobe, so a later `frame_end` with no new events sets nothing.
- R4: A pulse on `xact_evt[0]` is recorded only when `td_ioc` is 1 in the same cycle.
- R5: A pulse on `oper_evt[k]` sets status bit 2+k at the next clock edge, without waiting for `frame_end`.
- R6: A status write (`wr_en`=1, `wr_sel`=0) clears each status bit whose `wr_data` bit is 1. Bits written with 0 keep their value.
- R7: When a clear and a new set reach the same status bit in one cycle, the bit ends up set.
- R8: `irq_n` is 0 exactly when some schedule status bit has its enable bit set, or when any controller-fault status bit is set. Controller faults cannot be masked.
- R9: After `irq_n` goes to 0, it returns to 1 only through register writes, and only once every cause that drives it has been cleared or masked.
- R10: An enable write (`wr_en`=1, `wr_sel`=1) loads enable bits [1:0] from `wr_data`. A masked schedule event still sets its status bit but does not pull `irq_n` low. Reading with `rd_sel`=1 returns the enable bits with the upper bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xact_evt | input | NUM_XACT | Schedule event pulses: bit 0 is descriptor completion, bit 1 is transaction error |
| td_ioc | input | 1 | The completing descriptor asks for an interrupt |
| frame_end | input | 1 | Last transaction status of the frame has been written back |
| oper_evt | input | NUM_OPER | Controller-fault pulses |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 is status (write-1-to-clear), 1 is enable |
| wr_data | input | NUM_SRC | Write data |
| rd_sel | input | 1 | Read target: 0 is status, 1 is enable |
| rd_data | output | NUM_SRC | Read data |
| irq_n | output | 1 | Interrupt request, active low, level |

## Verification
The assertions assume that the event inputs and `frame_end` are single-cycle pulses that are sampled only after reset is released. They also assume that only the register port can lower the interrupt cause, so the line may drop only in a cycle that follows a write. The stimulus drives every input on the falling clock edge and holds each for exactly one rising edge. It returns every strobe to zero between vectors, so the pulse assumption is never broken. The stimulus deliberately lines up clears with new sets and events with `frame_end`, because those are the cases where the order inside a cycle decides the result.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;

    // Register targets on the access port
    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    // One decoded register-port command
    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
    } reg_cmd_t;

    // Index of the descriptor-completion cause inside the schedule group
    localparam int unsigned DONE_IDX = 0;

    // Next value of a write-one-to-clear bit: a set outranks a clear
    function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

    // Decode the raw port signals into a command
    function automatic reg_cmd_t decode_cmd(input logic wr_en, input logic wr_sel);
        reg_cmd_t c;
        c.wr  = wr_en;
        c.sel = reg_sel_e'(wr_sel);
        return c;
    endfunction

endpackage

// File: rtl/usbh_irq_frame_pend.sv
module usbh_irq_frame_pend #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         frame_end,
    output logic [W-1:0] pend,
    output logic [W-1:0] commit
);
    logic [W-1:0] pend_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // An event that coincides with the strobe goes to the closing frame
        assign commit[i] = frame_end & (pend_q[i] | evt[i]);

        always_ff @(posedge clk) begin
            if (rst)
                pend_q[i] <= 1'b0;
            else if (frame_end)
                pend_q[i] <= 1'b0;
            else if (evt[i])
                pend_q[i] <= 1'b1;
        end
    end

    assign pend = pend_q;

    // R3: the strobe leaves an empty pending set behind it
    a_r3_pend_empty: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (pend_q == '0));

    // R2: a pending flag can only appear after an event
    a_r2_pend_needs_evt: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) && !(|evt) |=> (pend_q == '0));

endmodule

// File: rtl/usbh_irq_status_w1c.sv
module usbh_irq_status_w1c #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    import usbh_irq_pkg::*;

    logic [W-1:0] q_r;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q_r[i] <= 1'b0;
            else
                q_r[i] <= w1c_next(q_r[i], set[i], clr[i]);
        end

        // R7: a set in the same cycle as a clear wins
        a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> q_r[i]);

        // R6: a clear with no competing set empties the bit
        a_r6_clear_takes: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set[i]) |=> !q_r[i]);

        // R6: without a set or a clear the bit keeps its value
        a_r6_hold: assert property (@(posedge clk) disable iff (rst)
            (!clr[i] && !set[i]) |=> $stable(q_r[i]));
    end

    assign q = q_r;

endmodule

// File: rtl/usbh_irq_level_out.sv
module usbh_irq_level_out #(
    parameter int unsigned NX = 2,
    parameter int unsigned NO = 2
) (
    input  logic [NX-1:0] stat_x,
    input  logic [NX-1:0] en_x,
    input  logic [NO-1:0] stat_o,
    output logic          irq_n
);
    logic [NX-1:0] live_x;
    logic          any_x;
    logic          any_o;

    for (genvar i = 0; i < NX; i++) begin : g_mask
        assign live_x[i] = stat_x[i] & en_x[i];
    end

    assign any_x = |live_x;
    assign any_o = |stat_o;
    assign irq_n = ~(any_x | any_o);

    always_comb begin
        // R8: a set fault bit always pulls the line low
        a_r8_fault_unmasked: assert (!any_o || !irq_n);
    end

endmodule

// File: rtl/usbh_irq_gather.sv
module usbh_irq_gather #(
    parameter int unsigned NUM_XACT = 2,
    parameter int unsigned NUM_OPER = 2,
    localparam int unsigned NUM_SRC = NUM_XACT + NUM_OPER
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_XACT-1:0] xact_evt,
    input  logic                td_ioc,
    input  logic                frame_end,
    input  logic [NUM_OPER-1:0] oper_evt,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [NUM_SRC-1:0]  wr_data,
    input  logic                rd_sel,
    output logic [NUM_SRC-1:0]  rd_data,
    output logic                irq_n
);
    import usbh_irq_pkg::*;

    reg_cmd_t            cmd;
    logic [NUM_XACT-1:0] evt_q;
    logic [NUM_XACT-1:0] pend_x;
    logic [NUM_XACT-1:0] commit_x;
    logic [NUM_XACT-1:0] clr_x;
    logic [NUM_OPER-1:0] clr_o;
    logic [NUM_XACT-1:0] stat_x;
    logic [NUM_OPER-1:0] stat_o;
    logic [NUM_XACT-1:0] en_q;

    assign cmd = decode_cmd(wr_en, wr_sel);

    // The completion cause counts only when the descriptor asked for it (R4)
    for (genvar i = 0; i < NUM_XACT; i++) begin : g_qual
        if (i == DONE_IDX) begin : g_done
            assign evt_q[i] = xact_evt[i] & td_ioc;
        end else begin : g_plain
            assign evt_q[i] = xact_evt[i];
        end
    end

    usbh_irq_frame_pend #(.W(NUM_XACT)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt_q),
        .frame_end (frame_end),
        .pend      (pend_x),
        .commit    (commit_x)
    );

    assign clr_x = (cmd.wr && cmd.sel == SEL_STATUS) ? wr_data[NUM_XACT-1:0] : '0;
    assign clr_o = (cmd.wr && cmd.sel == SEL_STATUS) ? wr_data[NUM_SRC-1:NUM_XACT] : '0;

    usbh_irq_status_w1c #(.W(NUM_XACT)) u_stat_x (
        .clk (clk),
        .rst (rst),
        .set (commit_x),
        .clr (clr_x),
        .q   (stat_x)
    );

    usbh_irq_status_w1c #(.W(NUM_OPER)) u_stat_o (
        .clk (clk),
        .rst (rst),
        .set (oper_evt),
        .clr (clr_o),
        .q   (stat_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (cmd.wr && cmd.sel == SEL_ENABLE)
            en_q <= wr_data[NUM_XACT-1:0];
    end

    usbh_irq_level_out #(.NX(NUM_XACT), .NO(NUM_OPER)) u_out (
        .stat_x (stat_x),
        .en_x   (en_q),
        .stat_o (stat_o),
        .irq_n  (irq_n)
    );

    always_comb begin
        if (reg_sel_e'(rd_sel) == SEL_ENABLE)
            rd_data = {{NUM_OPER{1'b0}}, en_q};
        else
            rd_data = {stat_o, stat_x};
    end

    for (genvar i = 0; i < NUM_XACT; i++) begin : g_chk_x
        // R2: a schedule status bit rises only on the frame strobe
        a_r2_deferred: assert property (@(posedge clk) disable iff (rst)
            $rose(stat_x[i]) |-> $past(frame_end));
    end

    for (genvar k = 0; k < NUM_OPER; k++) begin : g_chk_o
        // R5: faults land in status on the next edge
        a_r5_fault_now: assert property (@(posedge clk) disable iff (rst)
            oper_evt[k] |=> stat_o[k]);
    end

    // R9: without a register write the line cannot be released
    a_r9_hold_low: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !wr_en) |=> !irq_n);

    // R1: the line is released while reset is applied
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> irq_n);

endmodule

// File: tb/usbh_irq_gather_bench.sv
`timescale 1ns/1ps
module usbh_irq_gather_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] xact_evt = '0;
    logic       td_ioc = 1'b0;
    logic       frame_end = 1'b0;
    logic [1:0] oper_evt = '0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [3:0] wr_data = '0;
    logic       rd_sel = 1'b0;
    logic [3:0] rd_data;
    logic       irq_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    usbh_irq_gather u_usbh_irq_gather (
        .clk       (clk),
        .rst       (rst),
        .xact_evt  (xact_evt),
        .td_ioc    (td_ioc),
        .frame_end (frame_end),
        .oper_evt  (oper_evt),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .irq_n     (irq_n)
    );

    typedef struct packed {
        logic [1:0] xevt;
        logic       ioc;
        logic       eof;
        logic [1:0] oevt;
        logic       wen;
        logic       wsel;
        logic [3:0] wdata;
        logic [3:0] est;
        logic       eirq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 4'b0011, 4'b0000, 1'b1, 4'd10}, // R10 enable both
        '{2'b01, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 4'd2},  // R2 held pending
        '{2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 4'd2},  // R2 still hidden
        '{2'b00, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 4'b0000, 4'b0001, 1'b0, 4'd2},  // R2 visible
        '{2'b10, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 4'b0000, 4'b0011, 1'b0, 4'd3},  // R3 same-cycle
        '{2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 4'b0001, 4'b0010, 1'b0, 4'd9},  // R9 partial clear
        '{2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 4'b0010, 4'b0000, 1'b1, 4'd6},  // R6 clear rest
        '{2'b00, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 4'd3},  // R3 empty frame
        '{2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 4'd4},  // R4 no request
        '{2'b00, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 4'd4},  // R4 nothing lands
        '{2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 4'b0000, 4'b0100, 1'b0, 4'd5},  // R5 fault now
        '{2'b10, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 4'b0100, 4'b0000, 1'b1, 4'd6},  // R6 fault cleared
        '{2'b00, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 4'b0010, 4'b0010, 1'b0, 4'd7},  // R7 set beats clear
        '{2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 4'b0010, 4'b0000, 1'b1, 4'd6},  // R6
        '{2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 4'b0000, 4'b0000, 1'b1, 4'd10}, // R10 mask all
        '{2'b10, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 4'd2},  // R2
        '{2'b00, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 4'b0000, 4'b0010, 1'b1, 4'd10}, // R10 masked latch
        '{2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 4'b0010, 4'b0010, 1'b0, 4'd8},  // R8 unmask
        '{2'b00, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 4'b0000, 4'b1010, 1'b0, 4'd5},  // R5
        '{2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 4'b1010, 4'b0000, 1'b1, 4'd8}   // R8 all clear
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        xact_evt = '0; td_ioc = 1'b0; frame_end = 1'b0; oper_evt = '0;
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        #0.5;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        // R1 reset state while reset is held
        check("R1 status in reset", rd_data, 4'b0000);
        check("R1 irq_n in reset", {3'b000, irq_n}, 4'b0001);
        @(negedge clk);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            xact_evt = VECS[v].xevt;
            td_ioc   = VECS[v].ioc;
            frame_end = VECS[v].eof;
            oper_evt = VECS[v].oevt;
            wr_en    = VECS[v].wen;
            wr_sel   = VECS[v].wsel;
            wr_data  = VECS[v].wdata;
            step();
            check($sformatf("R%0d vec %0d status", VECS[v].req, v), rd_data, VECS[v].est);
            check($sformatf("R%0d vec %0d irq_n", VECS[v].req, v), {3'b000, irq_n}, {3'b000, VECS[v].eirq});
        end

        // R10 enable readback: enable holds 2'b10 from the table
        rd_sel = 1'b1;
        #0.5;
        check("R10 enable readback", rd_data, 4'b0010);
        rd_sel = 1'b0;

        // R5 / R8: fault pulls the line low even with all causes masked
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 4'b0000;
        step();
        oper_evt = 2'b01;
        step();
        check("R5 fault while masked status", rd_data, 4'b0100);
        check("R8 fault unmasked irq_n", {3'b000, irq_n}, 4'b0000);

        // R9: line stays low until the last fault is cleared
        oper_evt = 2'b10;
        step();
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b0100;
        step();
        check("R9 partial clear irq_n", {3'b000, irq_n}, 4'b0000);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b1000;
        step();
        check("R9 full clear irq_n", {3'b000, irq_n}, 4'b0001);

        // R1: reset in mid-run clears status, enable and pending
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 4'b0011;
        step();
        xact_evt = 2'b10; oper_evt = 2'b01;
        step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R1 status after reset", rd_data, 4'b0000);
        check("R1 irq_n after reset", {3'b000, irq_n}, 4'b0001);
        rd_sel = 1'b1;
        #0.5;
        check("R1 enable after reset", rd_data, 4'b0000);
        rd_sel = 1'b0;
        // R1 / R3: pending was emptied by reset, so a strobe sets nothing
        frame_end = 1'b1;
        step();
        check("R1 pending after reset", rd_data, 4'b0000);

        finish_run();
    end

endmodule